// File: doc/BRIEF.md
# Simplified Burst Slave Bridge with Bounded Wait

This block sits between a pipelined AHB-style system bus and a single user-built slave. It captures each address phase that targets a fixed address window and presents it to the slave during the matching data phase. The slave sees a select, a registered address, separate read and write strobes, the transfer size and the burst type, plus explicit flags for the first beat of a burst and for the beats that follow it.

The bridge keeps its own burst address tracker. Sequential beats take their address from the tracker, which increments by the transfer size or wraps inside a window of beats times size bytes. The slave can hold off completion with a wait request. A counter bounds the stall to a fixed number of cycles (16 by default) unless the slave also raises an ignore-timeout input, in which case the stall lasts as long as the wait request does. Read data goes back to the bus in the cycle the stall ends.

Top module: `simple_burst_bridge`

## Requirements
- R1: While reset is asserted and just after it, `usr_sel`, `usr_we`, `usr_re`, `usr_bstart` and `usr_bcont` are 0 and `hready_out` is 1.
- R2: An address phase with `hsel`=1, `htrans` NONSEQ (2) or SEQ (3), `hready_in`=1 and an address inside the window (`haddr & WIN_MASK == WIN_BASE`) gives, in the following cycle, `usr_sel`=1, `usr_we`=`hwrite`, `usr_re`=!`hwrite`, and `usr_size`/`usr_burst` equal to the captured `hsize`/`hburst`; exactly one of `usr_we` and `usr_re` is high while selected.
- R3: An address phase outside the window, or with `htrans` IDLE (0) or BUSY (1), leaves `usr_sel` low in the next cycle and completes with `hready_out`=1 regardless of `usr_wait`.
- R4: `usr_bstart` is 1 for a NONSEQ beat whose burst code is not SINGLE (0); `usr_bcont` is 1 for every SEQ beat; they are never both 1.
- R5: For burst codes SINGLE (0), INCR (1), INCR4 (3), INCR8 (5) and INCR16 (7), each SEQ beat's `usr_addr` equals the previous beat's address plus 2^`hsize`.
- R6: For WRAP4 (2), WRAP8 (4) and WRAP16 (6), each SEQ beat's `usr_addr` advances by 2^`hsize` and wraps inside the aligned window of 4, 8 or 16 beats times 2^`hsize` bytes.
- R7: While `usr_sel`=1 and `usr_wait`=1 before the timeout, `hready_out` is 0 and the slave-side outputs stay unchanged.
- R8: With `usr_ign_to`=0, a data phase stalls for min(W, 16) cycles, where W is the number of leading cycles `usr_wait` is held high.
- R9: With `usr_ign_to`=1, a data phase stalls for exactly W cycles, beyond 16.
- R10: In the completing cycle of a read, `hrdata` equals `usr_rdata`; during a write `usr_wdata` equals `hwdata`.
- R11: `usr_clk` equals `hclk` and `usr_rst_n` equals `hresetn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low reset |
| hsel | input | 1 | Slave select from bus decoder |
| haddr | input | 32 | Address-phase address |
| htrans | input | 2 | Transfer type (IDLE 0, BUSY 1, NONSEQ 2, SEQ 3) |
| hwrite | input | 1 | 1 for write |
| hsize | input | 3 | Transfer size, bytes = 2^hsize |
| hburst | input | 3 | Burst code |
| hwdata | input | 32 | Write data (data phase) |
| hready_in | input | 1 | Bus-wide ready, address phase is taken when high |
| hready_out | output | 1 | This slave's ready |
| hrdata | output | 32 | Read data to the bus |
| usr_clk | output | 1 | Clock for user logic |
| usr_rst_n | output | 1 | Reset for user logic |
| usr_sel | output | 1 | User slave selected for this data phase |
| usr_addr | output | 32 | Beat address |
| usr_wdata | output | 32 | Write data to slave |
| usr_rdata | input | 32 | Read data from slave |
| usr_we | output | 1 | Write strobe |
| usr_re | output | 1 | Read strobe |
| usr_size | output | 3 | Beat size |
| usr_burst | output | 3 | Burst code |
| usr_bstart | output | 1 | First beat of a burst |
| usr_bcont | output | 1 | Later beat of a burst |
| usr_wait | input | 1 | Slave requests a wait state |
| usr_ign_to | input | 1 | Disable the wait timeout |

## Verification
On every cycle the assertions check that an idle bridge is ready, that read and write strobes are exclusive while selected, that start and continue flags never coincide, that a stall holds the slave-side outputs, that the wait counter never passes its bound and that an expired count releases the bus, and that wrapped beats stay inside their window. The exact stall length for a given wait pattern, the address sequence of each burst type and size, the treatment of out-of-window accesses and the data returned in the completing cycle only show up in the bench's directed and random bursts, which compare against addresses and stall counts the bench computes itself.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
  localparam int ADDR_W = 32;

  typedef enum logic [1:0] {
    TR_IDLE = 2'd0,
    TR_BUSY = 2'd1,
    TR_NSEQ = 2'd2,
    TR_SEQ  = 2'd3
  } trans_e;

  localparam logic [2:0] BURST_SINGLE = 3'd0;

  // number of beats in a fixed-length burst (1 for SINGLE and INCR)
  function automatic logic [4:0] burst_beats(input logic [2:0] bu);
    case (bu)
      3'd2, 3'd3: return 5'd4;
      3'd4, 3'd5: return 5'd8;
      3'd6, 3'd7: return 5'd16;
      default:    return 5'd1;
    endcase
  endfunction

  function automatic logic burst_wraps(input logic [2:0] bu);
    return (bu != 3'd0) && !bu[0];
  endfunction

  // byte span of a wrapping window, minus one
  function automatic logic [ADDR_W-1:0] wrap_mask(input logic [2:0] sz, input logic [2:0] bu);
    logic [ADDR_W-1:0] span;
    span = {{(ADDR_W-5){1'b0}}, burst_beats(bu)} << sz;
    return span - 1'b1;
  endfunction

  function automatic logic [ADDR_W-1:0] next_beat_addr(input logic [ADDR_W-1:0] a,
                                                       input logic [2:0] sz,
                                                       input logic [2:0] bu);
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] msk;
    step = {{(ADDR_W-1){1'b0}}, 1'b1} << sz;
    sum  = a + step;
    msk  = wrap_mask(sz, bu);
    if (burst_wraps(bu)) return (a & ~msk) | (sum & msk);
    return sum;
  endfunction
endpackage

// File: rtl/sbb_addr_track.sv
module sbb_addr_track
  import sbb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              seq,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2:0]        size,
  input  logic [2:0]        burst,
  output logic [ADDR_W-1:0] beat_addr
);
  logic [ADDR_W-1:0] prev_q;

  assign beat_addr = seq ? next_beat_addr(prev_q, size, burst) : bus_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    prev_q <= '0;
    else if (load) prev_q <= beat_addr;
  end

  // R6
  wrap_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && seq && burst_wraps(burst)) |->
      ((beat_addr & ~wrap_mask(size, burst)) == (prev_q & ~wrap_mask(size, burst))));
endmodule

// File: rtl/sbb_wait_ctl.sv
module sbb_wait_ctl #(
  parameter int MAX_WAIT = 16,
  localparam int CW = $clog2(MAX_WAIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic wait_req,
  input  logic ign_to,
  output logic done,
  output logic tmo_hit
);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_WAIT);
  logic [CW-1:0] cnt_q;

  assign tmo_hit = active && wait_req && !ign_to && (cnt_q == LIMIT);
  assign done    = !active || !wait_req || tmo_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (done)             cnt_q <= '0;
    else if (cnt_q != LIMIT)   cnt_q <= cnt_q + 1'b1;
  end

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
endmodule

// File: rtl/simple_burst_bridge.sv
module simple_burst_bridge
  import sbb_pkg::*;
#(
  parameter int          DW       = 32,
  parameter int          MAX_WAIT = 16,
  parameter logic [31:0] WIN_BASE = 32'h4000_0000,
  parameter logic [31:0] WIN_MASK = 32'hF000_0000
) (
  input  logic          hclk,
  input  logic          hresetn,
  input  logic          hsel,
  input  logic [31:0]   haddr,
  input  logic [1:0]    htrans,
  input  logic          hwrite,
  input  logic [2:0]    hsize,
  input  logic [2:0]    hburst,
  input  logic [DW-1:0] hwdata,
  input  logic          hready_in,
  output logic          hready_out,
  output logic [DW-1:0] hrdata,
  output logic          usr_clk,
  output logic          usr_rst_n,
  output logic          usr_sel,
  output logic [31:0]   usr_addr,
  output logic [DW-1:0] usr_wdata,
  input  logic [DW-1:0] usr_rdata,
  output logic          usr_we,
  output logic          usr_re,
  output logic [2:0]    usr_size,
  output logic [2:0]    usr_burst,
  output logic          usr_bstart,
  output logic          usr_bcont,
  input  logic          usr_wait,
  input  logic          usr_ign_to
);
  // address-phase decode, brought out as named events
  logic in_window, is_xfer, is_seq, accept;
  assign in_window = (haddr & WIN_MASK) == WIN_BASE;
  assign is_xfer   = (htrans == TR_NSEQ) || (htrans == TR_SEQ);
  assign is_seq    = (htrans == TR_SEQ);
  assign accept    = hsel && is_xfer && in_window && hready_in;

  logic [ADDR_W-1:0] beat_addr;

  sbb_addr_track u_track (
    .clk       (hclk),
    .rst_n     (hresetn),
    .load      (accept),
    .seq       (is_seq),
    .bus_addr  (haddr),
    .size      (hsize),
    .burst     (hburst),
    .beat_addr (beat_addr)
  );

  // data-phase state
  logic              dp_active, dp_write, dp_seq;
  logic [ADDR_W-1:0] dp_addr;
  logic [2:0]        dp_size, dp_burst;

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      dp_active <= 1'b0;
      dp_write  <= 1'b0;
      dp_seq    <= 1'b0;
      dp_addr   <= '0;
      dp_size   <= '0;
      dp_burst  <= '0;
    end else if (hready_in) begin
      dp_active <= accept;
      if (accept) begin
        dp_write <= hwrite;
        dp_seq   <= is_seq;
        dp_addr  <= beat_addr;
        dp_size  <= hsize;
        dp_burst <= hburst;
      end
    end
  end

  logic wait_done, tmo_hit;

  sbb_wait_ctl #(.MAX_WAIT(MAX_WAIT)) u_wait (
    .clk      (hclk),
    .rst_n    (hresetn),
    .active   (dp_active),
    .wait_req (usr_wait),
    .ign_to   (usr_ign_to),
    .done     (wait_done),
    .tmo_hit  (tmo_hit)
  );

  assign hready_out = wait_done;
  assign hrdata     = (dp_active && !dp_write) ? usr_rdata : '0;
  assign usr_wdata  = hwdata;
  assign usr_clk    = hclk;
  assign usr_rst_n  = hresetn;
  assign usr_sel    = dp_active;
  assign usr_addr   = dp_addr;
  assign usr_we     = dp_active && dp_write;
  assign usr_re     = dp_active && !dp_write;
  assign usr_size   = dp_size;
  assign usr_burst  = dp_burst;
  assign usr_bstart = dp_active && !dp_seq && (dp_burst != BURST_SINGLE);
  assign usr_bcont  = dp_active && dp_seq;

  // R3
  idle_ready_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    !usr_sel |-> hready_out);

  // R2
  dir_excl_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    usr_sel |-> (usr_we != usr_re));

  // R4
  flag_excl_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    !(usr_bstart && usr_bcont));

  // R7
  stall_hold_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    (usr_sel && !hready_out) |=> (usr_sel && $stable(usr_addr) && $stable(usr_we) && $stable(usr_size)));

  // R8
  timeout_release_chk: assert property (@(posedge hclk) disable iff (!hresetn)
    tmo_hit |-> (hready_out && usr_sel));
endmodule

// File: tb/sim_simple_burst_bridge.sv
module sim_simple_burst_bridge;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hsel, hwrite, hready_out, hready_in;
  logic [31:0] haddr, hwdata, hrdata, usr_addr, usr_wdata, usr_rdata;
  logic [1:0]  htrans;
  logic [2:0]  hsize, hburst, usr_size, usr_burst;
  logic        usr_clk, usr_rst_n, usr_sel, usr_we, usr_re, usr_bstart, usr_bcont;
  logic        usr_wait, usr_ign_to;
  int          errs = 0, checks = 0;

  always #4 clk = ~clk;
  assign hready_in = hready_out;

  simple_burst_bridge u0 (
    .hclk(clk), .hresetn(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hburst(hburst), .hwdata(hwdata),
    .hready_in(hready_in), .hready_out(hready_out), .hrdata(hrdata),
    .usr_clk(usr_clk), .usr_rst_n(usr_rst_n), .usr_sel(usr_sel), .usr_addr(usr_addr),
    .usr_wdata(usr_wdata), .usr_rdata(usr_rdata), .usr_we(usr_we), .usr_re(usr_re),
    .usr_size(usr_size), .usr_burst(usr_burst), .usr_bstart(usr_bstart),
    .usr_bcont(usr_bcont), .usr_wait(usr_wait), .usr_ign_to(usr_ign_to)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nbeats(input logic [2:0] bu);
    if (bu == 3'd2 || bu == 3'd3) return 4;
    if (bu == 3'd4 || bu == 3'd5) return 8;
    if (bu == 3'd6 || bu == 3'd7) return 16;
    return 1;
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] start, input logic [2:0] sz,
                                           input logic [2:0] bu, input int k);
    longint bytes, span, base;
    bytes = longint'(1) << sz;
    if (bu == 3'd2 || bu == 3'd4 || bu == 3'd6) begin
      span = nbeats(bu) * bytes;
      base = (longint'(start) / span) * span;
      return 32'(base + ((longint'(start) - base + k * bytes) % span));
    end
    return 32'(longint'(start) + k * bytes);
  endfunction

  // one beat: address phase now, then data phase with wt leading wait cycles
  task automatic beat(input logic [1:0] tr, input logic [31:0] a, input logic wr,
                      input logic [2:0] sz, input logic [2:0] bu, input int wt,
                      input logic ign, input logic in_rng, input logic [31:0] ea,
                      input logic ebs, input logic ebc, input logic [1:0] gap,
                      input string atag);
    int n;
    int en;
    hsel = 1'b1; htrans = tr; haddr = a; hwrite = wr; hsize = sz; hburst = bu;
    usr_ign_to = ign; usr_wait = 1'b0;
    @(posedge clk); @(negedge clk);
    htrans = gap;
    hwdata = $urandom; usr_rdata = $urandom;
    usr_wait = (wt > 0);
    #1;
    if (!in_rng || tr[1] == 1'b0) begin
      chk("R3 sel", {31'b0, usr_sel}, 32'd0);
      chk("R3 ready", {31'b0, hready_out}, 32'd1);
    end else begin
      chk("R2 sel", {31'b0, usr_sel}, 32'd1);
      chk("R2 we", {31'b0, usr_we}, {31'b0, wr});
      chk("R2 re", {31'b0, usr_re}, {31'b0, !wr});
      chk("R2 size", {29'b0, usr_size}, {29'b0, sz});
      chk("R2 burst", {29'b0, usr_burst}, {29'b0, bu});
      chk(atag, usr_addr, ea);
      chk("R4 bstart", {31'b0, usr_bstart}, {31'b0, ebs});
      chk("R4 bcont", {31'b0, usr_bcont}, {31'b0, ebc});
      n = 0;
      while (hready_out !== 1'b1 && n < 200) begin
        @(posedge clk); @(negedge clk);
        n++;
        usr_wait = (n < wt);
        #1;
        if (hready_out !== 1'b1) chk("R7 hold", usr_addr, ea);
      end
      en = ign ? wt : (wt > 16 ? 16 : wt);
      chk(ign ? "R9 stall" : "R8 stall", n, en);
      if (!wr) chk("R10 rdata", hrdata, usr_rdata);
      else     chk("R10 wdata", usr_wdata, hwdata);
    end
    usr_wait = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic run_burst(input logic [31:0] start, input logic [2:0] sz, input logic [2:0] bu,
                           input int cnt, input logic wr, input int wmax, input logic ign);
    for (int k = 0; k < cnt; k++) begin
      logic [31:0] ea;
      ea = exp_addr(start, sz, bu, k);
      beat((k == 0) ? 2'd2 : 2'd3, ea, wr, sz, bu, $urandom_range(0, wmax), ign, 1'b1, ea,
           (k == 0) && (bu != 3'd0), k > 0, (k == cnt - 1) ? 2'd0 : 2'd1,
           (bu == 3'd2 || bu == 3'd4 || bu == 3'd6) ? "R6 addr" : "R5 addr");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; hsel = 1'b0; htrans = 2'd0; haddr = '0; hwrite = 1'b0; hsize = 3'd0;
    hburst = 3'd0; hwdata = '0; usr_rdata = '0; usr_wait = 1'b1; usr_ign_to = 1'b0;
    @(negedge clk); #1;
    // R1 reset state
    chk("R1 sel", {31'b0, usr_sel}, 32'd0);
    chk("R1 ready", {31'b0, hready_out}, 32'd1);
    chk("R1 strobes", {28'b0, usr_we, usr_re, usr_bstart, usr_bcont}, 32'd0);
    chk("R11 rst", {31'b0, usr_rst_n}, 32'd0);
    chk("R11 clk", {31'b0, usr_clk}, {31'b0, clk});
    repeat (2) @(negedge clk);
    rst_n = 1'b1; usr_wait = 1'b0;
    @(negedge clk); #1;
    chk("R1 sel after", {31'b0, usr_sel}, 32'd0);
    chk("R11 rst high", {31'b0, usr_rst_n}, 32'd1);

    // R3 out of window, and IDLE/BUSY transfers, ignored even with wait high
    beat(2'd2, 32'h5000_0010, 1'b0, 3'd2, 3'd0, 5, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 2'd0, "R3");
    beat(2'd0, 32'h4000_0010, 1'b1, 3'd2, 3'd0, 5, 1'b0, 1'b1, 32'h0, 1'b0, 1'b0, 2'd0, "R3");
    beat(2'd1, 32'h4000_0010, 1'b1, 3'd2, 3'd0, 5, 1'b0, 1'b1, 32'h0, 1'b0, 1'b0, 2'd0, "R3");

    // R8/R9 directed wait lengths on single transfers
    beat(2'd2, 32'h4000_0100, 1'b0, 3'd2, 3'd0, 0,  1'b0, 1'b1, 32'h4000_0100, 1'b0, 1'b0, 2'd0, "R2 addr");
    beat(2'd2, 32'h4000_0104, 1'b0, 3'd2, 3'd0, 15, 1'b0, 1'b1, 32'h4000_0104, 1'b0, 1'b0, 2'd0, "R2 addr");
    beat(2'd2, 32'h4000_0108, 1'b1, 3'd2, 3'd0, 16, 1'b0, 1'b1, 32'h4000_0108, 1'b0, 1'b0, 2'd0, "R2 addr");
    beat(2'd2, 32'h4000_010C, 1'b0, 3'd2, 3'd0, 17, 1'b0, 1'b1, 32'h4000_010C, 1'b0, 1'b0, 2'd0, "R2 addr");
    beat(2'd2, 32'h4000_0110, 1'b0, 3'd2, 3'd0, 40, 1'b0, 1'b1, 32'h4000_0110, 1'b0, 1'b0, 2'd0, "R2 addr");
    beat(2'd2, 32'h4000_0114, 1'b1, 3'd2, 3'd0, 40, 1'b1, 1'b1, 32'h4000_0114, 1'b0, 1'b0, 2'd0, "R2 addr");

    // R6 directed wrap corners: WRAP4 word from mid-window, WRAP8 halfword at window end
    run_burst(32'h4000_0038, 3'd2, 3'd2, 4, 1'b0, 2, 1'b0);
    run_burst(32'h4000_004E, 3'd1, 3'd4, 8, 1'b1, 2, 1'b0);
    run_burst(32'h4000_00FF, 3'd0, 3'd6, 16, 1'b0, 1, 1'b0);
    // R5 incrementing bursts
    run_burst(32'h4000_0200, 3'd2, 3'd1, 5, 1'b1, 3, 1'b0);
    run_burst(32'h4000_0300, 3'd1, 3'd7, 16, 1'b0, 1, 1'b0);

    // random bursts
    for (int i = 0; i < 60; i++) begin
      logic [2:0]  sz, bu;
      logic [31:0] st;
      int          cnt;
      sz  = 3'($urandom_range(0, 2));
      bu  = 3'($urandom_range(0, 7));
      st  = 32'h4000_0000 | ($urandom & 32'h0000_FFF0) | ($urandom & 32'h0000_000F);
      st  = st & ~((32'd1 << sz) - 32'd1);
      cnt = (bu == 3'd1) ? $urandom_range(1, 6) : nbeats(bu);
      run_burst(st, sz, bu, cnt, 1'($urandom), 22, 1'($urandom));
    end

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule